// File: doc/BRIEF.md
# Segment Hash and Miss-Register Generator

This block sits in front of a software-refilled page translation unit. It holds sixteen segment registers and, for each access request, chooses one of them with the top four address bits. From the chosen segment it derives the protection key for the current privilege level, the direct-store and no-execute flags, the primary page-table hash and the compare word that a TLB entry must carry. The TLB itself is outside the block. It reports its lookup outcome for the same request as a hit, a miss or a protection failure.

From that outcome, or from the segment flags alone, the block builds the fault record that a refill handler reads: an exception class, an error code, the faulting address, the compare value with its miss marker, both page-group addresses in the hashed page table, and a data status word. Accesses to direct-store segments are resolved here without the TLB. Cache-control operations and permitted integer accesses pass through with an untranslated address. All other access classes raise their own fault codes. Every result is registered and appears one clock after the request.

Top module: `seghash_unit`

## Requirements
- R1: A segment register written through `seg_we`/`seg_sel`/`seg_wdata` is selected by request address bits 31:28. Within it, bit 31 is the direct-store flag, bit 30 is the supervisor key, bit 29 is the user key, bit 28 is no-execute and bits 23:0 are the segment id. `ctx_key` is the user key when `req_user`=1 and the supervisor key otherwise.
- R2: `ctx_hash` = segment id XOR address bits 27:12. `ctx_cmp` = (segment id << 7) | address bits 27:22.
- R3: After reset all valid outputs are 0. `ctx_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1, and all results appear in that cycle. Access class codes are 0 fetch, 1 integer, 2 floating point, 3 reserved load/store, 4 external control and 5 cache control; codes 6 and 7 act as integer. `tlb_res` uses 1 for miss and 2 for protection failure; any other value is a hit.
- R4: A fetch (class 0) in a segment that is not direct-store but is marked no-execute raises `flt_class`=4 with code 0x10000000, whatever `tlb_res` says.
- R5: A fetch miss gives `flt_class`=1 and code (1<<18) | (key<<19). `flt_addr` is the request address, which is also true of every fault.
- R6: A data miss gives `flt_class`=3 and code (1<<16)|(key<<19) for a store, or `flt_class`=2 and code key<<19 for a load.
- R7: On any miss `flt_cmp` = compare word | 0x80000000. `flt_hash1` = `pt_base` + ((hash<<6) & `pt_mask`). `flt_hash2` = `pt_base` + ((~hash<<6) & `pt_mask`), with the hash taken as 24 bits. For all other faults these three fields are 0.
- R8: A protection failure on a fetch gives class 4 with code 0x08000000. On a data access it gives class 5, code 0, and `flt_status` 0x0A000000 for a store or 0x08000000 for a load.
- R9: In a direct-store segment, class 3 gives class 5 with status 0x06000000 for a store and 0x04000000 for a load. Class 4 gives status 0x06100000 for a store and 0x04100000 for a load.
- R10: In a direct-store segment, a fetch gives class 4 with code 0x10000000 and a floating-point access gives class 6 with code 0.
- R11: In a direct-store segment, cache control sets `dir_valid` with `dir_addr` equal to the request address and raises no fault. An integer access passes the same way when it is a store with key 1 or a load with key 0. Any other integer access gives class 5 with status 0x0A000000 for a store or 0x08000000 for a load.
- R12: A hit in a segment that is not direct-store, and that is not a fetch to a no-execute segment, gives no fault and no pass-through. All fault fields then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_sel | input | 4 | Segment register written |
| seg_wdata | input | 32 | Segment register write value |
| req_valid | input | 1 | Request strobe |
| req_ea | input | 32 | Request address |
| req_class | input | 3 | Access class code |
| req_store | input | 1 | 1 for a store |
| req_user | input | 1 | 1 for user privilege |
| tlb_res | input | 2 | TLB outcome for this request |
| pt_base | input | 32 | Hashed page-table base |
| pt_mask | input | 32 | Hashed page-table offset mask |
| ctx_valid | output | 1 | Context outputs valid |
| ctx_key | output | 1 | Selected protection key |
| ctx_ds | output | 1 | Direct-store segment |
| ctx_nx | output | 1 | No-execute segment |
| ctx_hash | output | 24 | Primary hash |
| ctx_cmp | output | 32 | TLB compare word |
| dir_valid | output | 1 | Direct-store pass-through |
| dir_addr | output | 32 | Pass-through address |
| flt_valid | output | 1 | Fault record strobe |
| flt_class | output | 3 | Exception class |
| flt_code | output | 32 | Error code |
| flt_addr | output | 32 | Faulting address |
| flt_cmp | output | 32 | Compare value with miss marker |
| flt_hash1 | output | 32 | Primary page-group address |
| flt_hash2 | output | 32 | Secondary page-group address |
| flt_status | output | 32 | Data status word |

## Verification
A corrupted segment register shows up on the next request that selects it, as a wrong key, flag, hash or compare word one cycle after the request. Because the bench routes every segment through random traffic, such a fault is seen within a few requests. An error in the group-offset arithmetic appears only on misses, in both page-group fields, and an error in the fault-selection order appears as the wrong class or status. Because every output is registered from one request, a fault never hides behind earlier traffic: each request's record is compared in full at the single cycle where it must appear.

// File: rtl/seghash_pkg.sv
// Shared encodings for the segment hash and fault generator.
// Assumes a 32-bit address space with 4 KiB pages and 256 MiB segments.
package seghash_pkg;
    typedef enum logic [2:0] {
        AC_CODE  = 3'd0,
        AC_INT   = 3'd1,
        AC_FLOAT = 3'd2,
        AC_RES   = 3'd3,
        AC_EXT   = 3'd4,
        AC_CACHE = 3'd5
    } acc_class_e;

    typedef enum logic [1:0] {
        TR_HIT  = 2'd0,
        TR_MISS = 2'd1,
        TR_PROT = 2'd2
    } tlb_res_e;

    typedef enum logic [2:0] {
        EX_NONE  = 3'd0,
        EX_ITLB  = 3'd1,
        EX_DLTLB = 3'd2,
        EX_DSTLB = 3'd3,
        EX_ISI   = 3'd4,
        EX_DSI   = 3'd5,
        EX_ALIGN = 3'd6
    } exc_e;

    localparam logic [31:0] CODE_NOEXEC   = 32'h1000_0000;
    localparam logic [31:0] CODE_PROT     = 32'h0800_0000;
    localparam logic [31:0] ST_PROT_ST    = 32'h0A00_0000;
    localparam logic [31:0] ST_PROT_LD    = 32'h0800_0000;
    localparam logic [31:0] ST_RES_ST     = 32'h0600_0000;
    localparam logic [31:0] ST_RES_LD     = 32'h0400_0000;
    localparam logic [31:0] ST_EXT_ST     = 32'h0610_0000;
    localparam logic [31:0] ST_EXT_LD     = 32'h0410_0000;
    localparam logic [31:0] MISS_MARK     = 32'h8000_0000;
endpackage

// File: rtl/seghash_segfile.sv
// Segment register file.
// Holds NSEG entries and stores only the bits the datapath uses: the four
// flag bits above the segment id, then the id. Reads are asynchronous, and a
// write becomes visible from the cycle after its strobe.
module seghash_segfile #(
    parameter int NSEG   = 16,
    parameter int VSID_W = 24,
    parameter int FLAG_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(NSEG)-1:0]       wsel,
    input  logic [31:0]                   wdata,
    input  logic [$clog2(NSEG)-1:0]       rsel,
    output logic [FLAG_W+VSID_W-1:0]      rdata
);
    localparam int ENT_W = FLAG_W + VSID_W;

    logic [ENT_W-1:0] ent [NSEG];
    logic [ENT_W-1:0] packed_w;

    // Compact the write value to flags plus id.
    assign packed_w = {wdata[31 -: FLAG_W], wdata[VSID_W-1:0]};

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        // One entry: cleared on reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[i] <= '0;
            else if (we && (wsel == i[$clog2(NSEG)-1:0]))
                ent[i] <= packed_w;
        end
    end

    // Read the entry picked by the request.
    assign rdata = ent[rsel];
endmodule

// File: rtl/seghash_calc.sv
// Segment context and page-group address calculation.
// Input seg is {ds, ks, kp, nx, vsid}. Produces the key for the current
// privilege, the primary hash and compare word, and both page-group
// addresses: base plus (hash or its complement, shifted) masked.
module seghash_calc #(
    parameter int VSID_W    = 24,
    parameter int PAGE_SH   = 12,
    parameter int PIDX_W    = 16,
    parameter int API_W     = 6,
    parameter int CMP_SH    = 7,
    parameter int GRP_SH    = 6
) (
    input  logic [VSID_W+3:0]  seg,
    input  logic [31:0]        ea,
    input  logic               user,
    input  logic [31:0]        base,
    input  logic [31:0]        mask,
    output logic               key,
    output logic               ds,
    output logic               nx,
    output logic [VSID_W-1:0]  hash,
    output logic [31:0]        cmp,
    output logic [31:0]        grp1,
    output logic [31:0]        grp2
);
    localparam int PAD_H = 32 - VSID_W - GRP_SH;
    localparam int PAD_C = 32 - VSID_W - CMP_SH;

    logic [VSID_W-1:0] vsid;
    logic [PIDX_W-1:0] pidx;
    logic [API_W-1:0]  api;
    logic [VSID_W-1:0] hsel [2];
    logic [31:0]       grp  [2];

    // Split the segment entry and the address into fields.
    assign ds   = seg[VSID_W+3];
    assign key  = user ? seg[VSID_W+1] : seg[VSID_W+2];
    assign nx   = seg[VSID_W];
    assign vsid = seg[VSID_W-1:0];
    assign pidx = ea[PAGE_SH +: PIDX_W];
    assign api  = pidx[PIDX_W-1 -: API_W];

    // Hash and compare word.
    assign hash = vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx};
    assign cmp  = {{PAD_C{1'b0}}, vsid, {(CMP_SH-API_W){1'b0}}, api};

    assign hsel[0] = hash;
    assign hsel[1] = ~hash;

    for (genvar g = 0; g < 2; g++) begin : g_grp
        // Page-group address for the primary or complemented hash.
        assign grp[g] = base + ({{PAD_H{1'b0}}, hsel[g], {GRP_SH{1'b0}}} & mask);
    end

    assign grp1 = grp[0];
    assign grp2 = grp[1];
endmodule

// File: rtl/seghash_fault.sv
// Fault classification and error-code encoding.
// Resolves one request from the segment flags, the key, the access class,
// store/load and the TLB outcome. Direct-store segments never use the TLB
// outcome. Purely combinational.
module seghash_fault
    import seghash_pkg::*;
(
    input  logic        ds,
    input  logic        nx,
    input  logic        key,
    input  logic [2:0]  acls,
    input  logic        store,
    input  logic [1:0]  tres,
    input  logic [31:0] cmp,
    input  logic [31:0] grp1,
    input  logic [31:0] grp2,
    output logic        fault,
    output logic        pass,
    output exc_e        cls,
    output logic [31:0] code,
    output logic [31:0] fcmp,
    output logic [31:0] h1,
    output logic [31:0] h2,
    output logic [31:0] status
);
    logic        fetch;
    logic [31:0] key_bits;

    assign fetch    = (acls == AC_CODE);
    assign key_bits = {12'd0, key, 19'd0};

    // Pick the fault class and its payload.
    always_comb begin
        fault  = 1'b0;
        pass   = 1'b0;
        cls    = EX_NONE;
        code   = '0;
        fcmp   = '0;
        h1     = '0;
        h2     = '0;
        status = '0;
        if (!ds) begin
            if (fetch && nx) begin
                fault = 1'b1;
                cls   = EX_ISI;
                code  = CODE_NOEXEC;
            end else if (tres == TR_MISS) begin
                fault = 1'b1;
                fcmp  = cmp | MISS_MARK;
                h1    = grp1;
                h2    = grp2;
                if (fetch) begin
                    cls  = EX_ITLB;
                    code = key_bits | 32'h0004_0000;
                end else if (store) begin
                    cls  = EX_DSTLB;
                    code = key_bits | 32'h0001_0000;
                end else begin
                    cls  = EX_DLTLB;
                    code = key_bits;
                end
            end else if (tres == TR_PROT) begin
                fault = 1'b1;
                if (fetch) begin
                    cls  = EX_ISI;
                    code = CODE_PROT;
                end else begin
                    cls    = EX_DSI;
                    status = store ? ST_PROT_ST : ST_PROT_LD;
                end
            end
        end else begin
            case (acls)
                AC_CACHE: pass = 1'b1;
                AC_CODE: begin
                    fault = 1'b1;
                    cls   = EX_ISI;
                    code  = CODE_NOEXEC;
                end
                AC_FLOAT: begin
                    fault = 1'b1;
                    cls   = EX_ALIGN;
                end
                AC_RES: begin
                    fault  = 1'b1;
                    cls    = EX_DSI;
                    status = store ? ST_RES_ST : ST_RES_LD;
                end
                AC_EXT: begin
                    fault  = 1'b1;
                    cls    = EX_DSI;
                    status = store ? ST_EXT_ST : ST_EXT_LD;
                end
                default: begin
                    if (store ? key : !key) begin
                        pass = 1'b1;
                    end else begin
                        fault  = 1'b1;
                        cls    = EX_DSI;
                        status = store ? ST_PROT_ST : ST_PROT_LD;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/seghash_unit.sv
// Segment hash and miss-register generator, top level.
// Selects a segment register by address bits 31:28, computes the
// translation context and, with the TLB outcome of the same request, the
// fault record. Every output is registered: results appear one clock after
// req_valid. Assumes the TLB outcome arrives together with the request.
module seghash_unit
    import seghash_pkg::*;
#(
    parameter int NSEG   = 16,
    parameter int VSID_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seg_we,
    input  logic [3:0]          seg_sel,
    input  logic [31:0]         seg_wdata,
    input  logic                req_valid,
    input  logic [31:0]         req_ea,
    input  logic [2:0]          req_class,
    input  logic                req_store,
    input  logic                req_user,
    input  logic [1:0]          tlb_res,
    input  logic [31:0]         pt_base,
    input  logic [31:0]         pt_mask,
    output logic                ctx_valid,
    output logic                ctx_key,
    output logic                ctx_ds,
    output logic                ctx_nx,
    output logic [VSID_W-1:0]   ctx_hash,
    output logic [31:0]         ctx_cmp,
    output logic                dir_valid,
    output logic [31:0]         dir_addr,
    output logic                flt_valid,
    output logic [2:0]          flt_class,
    output logic [31:0]         flt_code,
    output logic [31:0]         flt_addr,
    output logic [31:0]         flt_cmp,
    output logic [31:0]         flt_hash1,
    output logic [31:0]         flt_hash2,
    output logic [31:0]         flt_status
);
    localparam int SEL_W = $clog2(NSEG);
    localparam int ENT_W = VSID_W + 4;

    logic [ENT_W-1:0]  seg_ent;
    logic              c_key, c_ds, c_nx;
    logic [VSID_W-1:0] c_hash;
    logic [31:0]       c_cmp, c_g1, c_g2;
    logic              f_fault, f_pass;
    exc_e              f_cls;
    logic [31:0]       f_code, f_cmp, f_h1, f_h2, f_status;

    seghash_segfile #(.NSEG(NSEG), .VSID_W(VSID_W), .FLAG_W(4)) u_segs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .wsel  (seg_sel[SEL_W-1:0]),
        .wdata (seg_wdata),
        .rsel  (req_ea[31 -: SEL_W]),
        .rdata (seg_ent)
    );

    seghash_calc #(.VSID_W(VSID_W)) u_calc (
        .seg  (seg_ent),
        .ea   (req_ea),
        .user (req_user),
        .base (pt_base),
        .mask (pt_mask),
        .key  (c_key),
        .ds   (c_ds),
        .nx   (c_nx),
        .hash (c_hash),
        .cmp  (c_cmp),
        .grp1 (c_g1),
        .grp2 (c_g2)
    );

    seghash_fault u_flt (
        .ds     (c_ds),
        .nx     (c_nx),
        .key    (c_key),
        .acls   (req_class),
        .store  (req_store),
        .tres   (tlb_res),
        .cmp    (c_cmp),
        .grp1   (c_g1),
        .grp2   (c_g2),
        .fault  (f_fault),
        .pass   (f_pass),
        .cls    (f_cls),
        .code   (f_code),
        .fcmp   (f_cmp),
        .h1     (f_h1),
        .h2     (f_h2),
        .status (f_status)
    );

    // Strobes: one cycle after each request, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_valid <= 1'b0;
            flt_valid <= 1'b0;
            dir_valid <= 1'b0;
        end else begin
            ctx_valid <= req_valid;
            flt_valid <= req_valid & f_fault;
            dir_valid <= req_valid & f_pass;
        end
    end

    // Payload: captured on each request, held between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_key    <= 1'b0;
            ctx_ds     <= 1'b0;
            ctx_nx     <= 1'b0;
            ctx_hash   <= '0;
            ctx_cmp    <= '0;
            dir_addr   <= '0;
            flt_class  <= '0;
            flt_code   <= '0;
            flt_addr   <= '0;
            flt_cmp    <= '0;
            flt_hash1  <= '0;
            flt_hash2  <= '0;
            flt_status <= '0;
        end else if (req_valid) begin
            ctx_key    <= c_key;
            ctx_ds     <= c_ds;
            ctx_nx     <= c_nx;
            ctx_hash   <= c_hash;
            ctx_cmp    <= c_cmp;
            dir_addr   <= f_pass ? req_ea : '0;
            flt_class  <= f_cls;
            flt_code   <= f_code;
            flt_addr   <= f_fault ? req_ea : '0;
            flt_cmp    <= f_cmp;
            flt_hash1  <= f_h1;
            flt_hash2  <= f_h2;
            flt_status <= f_status;
        end
    end
endmodule

// File: rtl/seghash_chk.sv
// Protocol checks on the ports of seghash_unit, attached by bind.
module seghash_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        ctx_valid,
    input logic        dir_valid,
    input logic        flt_valid,
    input logic [2:0]  flt_class,
    input logic [31:0] flt_code,
    input logic [31:0] flt_cmp,
    input logic [31:0] flt_status
);
    // R3
    ctx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ctx_valid);

    // R3
    ctx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !ctx_valid && !flt_valid && !dir_valid);

    // R12
    fault_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ctx_valid && (flt_class != 3'd0));

    // R11
    pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_valid && flt_valid));

    // R7
    miss_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && (flt_class >= 3'd1) && (flt_class <= 3'd3)
        |-> (flt_cmp != 32'd0) && flt_cmp[31]);

    // R5
    fetch_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && (flt_class == 3'd1) |-> flt_code[18] && !flt_code[16]);

    // R8
    dsi_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && (flt_class == 3'd5) |-> (flt_code == 32'd0) && (flt_status != 32'd0));
endmodule

bind seghash_unit seghash_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .ctx_valid  (ctx_valid),
    .dir_valid  (dir_valid),
    .flt_valid  (flt_valid),
    .flt_class  (flt_class),
    .flt_code   (flt_code),
    .flt_cmp    (flt_cmp),
    .flt_status (flt_status)
);

// File: tb/sim_seghash_unit.sv
// Bench for seghash_unit: seeded random traffic plus directed corners,
// compared against a model written from the requirements.
module sim_seghash_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_sel = '0;
    logic [31:0] seg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_ea = '0;
    logic [2:0]  req_class = '0;
    logic        req_store = 1'b0;
    logic        req_user = 1'b0;
    logic [1:0]  tlb_res = '0;
    logic [31:0] pt_base = '0;
    logic [31:0] pt_mask = '0;
    logic        ctx_valid, ctx_key, ctx_ds, ctx_nx;
    logic [23:0] ctx_hash;
    logic [31:0] ctx_cmp;
    logic        dir_valid;
    logic [31:0] dir_addr;
    logic        flt_valid;
    logic [2:0]  flt_class;
    logic [31:0] flt_code, flt_addr, flt_cmp, flt_hash1, flt_hash2, flt_status;

    int total = 0;
    int bad = 0;
    logic [31:0] segm [16];

    // expected values
    logic        e_key, e_ds, e_nx, e_fv, e_dv;
    logic [23:0] e_hash;
    logic [31:0] e_cmp, e_code, e_faddr, e_fcmp, e_h1, e_h2, e_stat, e_daddr;
    logic [2:0]  e_cls;
    string       e_tag;

    always #2 clk = ~clk;

    seghash_unit u0 (.*);

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end (act=hung exp=done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_seg(input int idx, input logic [31:0] v);
        @(negedge clk);
        seg_we = 1'b1;
        seg_sel = 4'(idx);
        seg_wdata = v;
        segm[idx] = v;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic predict(input logic [31:0] ea, input logic [2:0] c,
                           input logic st, input logic usr, input logic [1:0] r);
        logic [31:0] s;
        logic [23:0] vsid;
        logic [15:0] pidx;
        logic        allow;
        s = segm[ea[31:28]];
        vsid = s[23:0];
        pidx = ea[27:12];
        e_ds = s[31];
        e_key = usr ? s[29] : s[30];
        e_nx = s[28];
        e_hash = vsid ^ {8'd0, pidx};
        e_cmp = {1'b0, vsid, 1'b0, pidx[15:10]};
        e_fv = 0; e_dv = 0; e_cls = 0; e_code = 0; e_fcmp = 0;
        e_h1 = 0; e_h2 = 0; e_stat = 0; e_daddr = 0;
        e_tag = "R12";
        if (!e_ds) begin
            if (c == 0 && e_nx) begin
                e_fv = 1; e_cls = 4; e_code = 32'h1000_0000; e_tag = "R4";
            end else if (r == 1) begin
                e_fv = 1;
                e_fcmp = e_cmp | 32'h8000_0000;
                e_h1 = pt_base + ({2'b0, e_hash, 6'b0} & pt_mask);
                e_h2 = pt_base + ({2'b0, ~e_hash, 6'b0} & pt_mask);
                if (c == 0) begin
                    e_cls = 1; e_code = 32'h0004_0000; e_tag = "R5";
                end else if (st) begin
                    e_cls = 3; e_code = 32'h0001_0000; e_tag = "R6";
                end else begin
                    e_cls = 2; e_code = 0; e_tag = "R6";
                end
                e_code = e_code | (32'(e_key) << 19);
            end else if (r == 2) begin
                e_fv = 1; e_tag = "R8";
                if (c == 0) begin
                    e_cls = 4; e_code = 32'h0800_0000;
                end else begin
                    e_cls = 5; e_stat = st ? 32'h0A00_0000 : 32'h0800_0000;
                end
            end
        end else begin
            case (c)
                3'd5: begin e_dv = 1; e_daddr = ea; e_tag = "R11"; end
                3'd0: begin e_fv = 1; e_cls = 4; e_code = 32'h1000_0000; e_tag = "R10"; end
                3'd2: begin e_fv = 1; e_cls = 6; e_tag = "R10"; end
                3'd3: begin e_fv = 1; e_cls = 5; e_stat = st ? 32'h0600_0000 : 32'h0400_0000; e_tag = "R9"; end
                3'd4: begin e_fv = 1; e_cls = 5; e_stat = st ? 32'h0610_0000 : 32'h0410_0000; e_tag = "R9"; end
                default: begin
                    e_tag = "R11";
                    allow = st ? e_key : !e_key;
                    if (allow) begin
                        e_dv = 1; e_daddr = ea;
                    end else begin
                        e_fv = 1; e_cls = 5; e_stat = st ? 32'h0A00_0000 : 32'h0800_0000;
                    end
                end
            endcase
        end
        e_faddr = e_fv ? ea : 32'd0;
    endtask

    // Issue one request (inputs change just after a falling edge) and
    // compare all results at the next falling edge.
    task automatic run_req(input logic [31:0] ea, input logic [2:0] c,
                           input logic st, input logic usr, input logic [1:0] r);
        @(negedge clk);
        req_valid = 1; req_ea = ea; req_class = c; req_store = st;
        req_user = usr; tlb_res = r;
        predict(ea, c, st, usr, r);
        @(negedge clk);
        req_valid = 0;
        chk("R3 ctx_valid", 64'(ctx_valid), 64'd1);
        chk("R1 key/ds/nx", 64'({ctx_key, ctx_ds, ctx_nx}), 64'({e_key, e_ds, e_nx}));
        chk("R2 hash/cmp", {8'd0, ctx_hash, ctx_cmp}, {8'd0, e_hash, e_cmp});
        chk({e_tag, " strobes/class"}, 64'({flt_valid, dir_valid, flt_class}), 64'({e_fv, e_dv, e_cls}));
        chk({e_tag, " code/addr"}, {flt_code, flt_addr}, {e_code, e_faddr});
        chk({e_tag, " R7 cmp"}, 64'(flt_cmp), 64'(e_fcmp));
        chk({e_tag, " R7 hash1/2"}, {flt_hash1, flt_hash2}, {e_h1, e_h2});
        chk({e_tag, " status/dir"}, {flt_status, dir_addr}, {e_stat, e_daddr});
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) segm[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R3: reset state
        chk("R3 reset strobes", 64'({ctx_valid, flt_valid, dir_valid}), 64'd0);

        pt_base = 32'h0010_0000;
        pt_mask = 32'h0000_FFC0;

        // Directed corners
        wr_seg(0, 32'h0012_3456);              // plain, key 0 supervisor
        wr_seg(1, 32'h7000_0001);              // ks=kp=1, nx
        wr_seg(15, 32'hC0FF_FFFF);             // direct-store, ks=1
        wr_seg(14, 32'h8000_0000);             // direct-store, keys 0
        run_req(32'h0ABC_D123, 3'd1, 0, 0, 2'd0); // R12 hit
        run_req(32'h1000_0000, 3'd0, 0, 1, 2'd1); // R4 nx overrides miss
        run_req(32'h1FFF_F000, 3'd1, 1, 1, 2'd1); // R6 store miss key 1
        run_req(32'h0FFF_FFFF, 3'd0, 0, 0, 2'd1); // R5 fetch miss
        run_req(32'h0000_0000, 3'd1, 0, 0, 2'd2); // R8 load prot
        run_req(32'hFFFF_FFFF, 3'd1, 1, 0, 2'd1); // R11 ds int store key1 pass
        run_req(32'hEAAA_5555, 3'd1, 1, 0, 2'd0); // R11 ds int store key0 denied
        run_req(32'hE000_0040, 3'd5, 0, 0, 2'd1); // R11 cache passes
        run_req(32'hE123_4567, 3'd3, 1, 0, 2'd0); // R9
        run_req(32'hE123_4567, 3'd4, 0, 0, 2'd0); // R9
        run_req(32'hE123_4567, 3'd2, 0, 0, 2'd0); // R10
        pt_mask = 32'hFFFF_FFFF;
        run_req(32'h0FFF_F000, 3'd2, 0, 1, 2'd1); // R7 full mask
        // R3: idle cycle after last request clears strobes
        @(negedge clk);
        chk("R3 idle", 64'({ctx_valid, flt_valid, dir_valid}), 64'd0);

        // Random traffic
        for (int i = 0; i < 16; i++) begin
            logic [31:0] v;
            v = $urandom;
            if (($urandom % 4) != 0) v[31] = 1'b0;
            wr_seg(i, v);
        end
        for (int n = 0; n < 600; n++) begin
            logic [2:0] c;
            logic       st;
            if ((n % 50) == 0) begin
                logic [31:0] v;
                v = $urandom;
                if (($urandom % 4) != 0) v[31] = 1'b0;
                wr_seg(int'($urandom % 16), v);
                pt_base = {$urandom, 16'h0} & 32'hFFF0_0000;
                pt_mask = 32'h0000_FFC0 | ({$urandom} & 32'h01FF_0000);
            end
            c = 3'($urandom % 6);
            st = (c == 3'd0) ? 1'b0 : 1'($urandom);
            run_req($urandom, c, st, 1'($urandom), 2'($urandom % 3));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule